// File: doc/BRIEF.md
# ADC Conversion Sequencer with Buffered Channel Selection

This block is the digital control sequencer of a successive-approximation converter. It runs on the system clock. A tick input, `half_tick`, pulses at twice the converter clock rate, so every event lands on an exact half-cycle. An internal phase bit marks which ticks are rising converter-clock edges. Tick 0 after reset is a rising edge, and from then on rising and falling ticks alternate.

Conversions can start in three ways: a software start strobe, an external trigger, or the completion of the previous conversion when the block is free-running. Each start opens a timed window. The block pulses `sh_pulse` at the sample-and-hold point, pulses `res_latch` when the result must be captured, and sets a sticky completion flag. A conversion is one of three kinds, and each kind has its own length and sample point.

The CPU writes the channel/reference select word into a shadow register. The shadow register is copied into the active register on every clock, except while a conversion is locked: from its start up to its last converter cycle. The comparator, the DAC and the result bits are outside this block. There is no data stream, so no handshake or back-pressure applies. All pins are plain control and status signals.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag`, `sh_pulse`, `res_latch` and `sel_active` are all 0.
- R2: While no conversion runs, `sel_active` equals the last value written through `sel_wr`/`sel_wdata`, no later than the second clock after the write.
- R3: `sel_active` holds the value copied at the start of a conversion, until the start of that conversion's final converter cycle.
- R4: From the tick that begins the final converter cycle (half-step LEN-2), the shadow value is copied to `sel_active` again, before completion.
- R5: With `en` high, a software start becomes a conversion at the first even-indexed tick (rising edge) strictly after the write. `busy` reads 1 from the clock after the write until completion.
- R6: The first conversion after reset or re-enable lasts 50 half-steps, with sample-and-hold at half-step 27. The first conversion takes priority over the other kinds.
- R7: A software-started conversion that is not the first lasts 26 half-steps, with sample-and-hold at half-step 3.
- R8: With `en` and `auto_en` high, an idle `trig` pulse starts an auto-triggered conversion at the next rising edge. It lasts 27 half-steps, with sample-and-hold at half-step 4.
- R9: With `en`, `auto_en` and `free_run` high, each completion starts the next auto-triggered conversion on the same tick, so completions are 27 half-steps apart.
- R10: At completion, `res_latch` is a one-clock pulse and `done_flag` is set in that same clock. The flag stays set until `flag_clr`; a completion in the same clock wins over the clear.
- R11: Lowering `en` aborts a running conversion within one clock, with no further `sh_pulse` or `res_latch`. The next conversion is then a first conversion.
- R12: `start_wr` and `trig` are ignored while `en` is low, and `trig` is ignored while `auto_en` is low. `busy` stays 0 and no conversion completes.
- R13: `sh_pulse` is a one-clock pulse, once per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-clock pulse at twice the converter clock rate |
| en | input | 1 | Converter enable; low aborts and re-arms the first-conversion timing |
| auto_en | input | 1 | Lets `trig` (and chaining) start conversions |
| free_run | input | 1 | With `auto_en`, each completion starts the next conversion |
| start_wr | input | 1 | Software start strobe |
| trig | input | 1 | External trigger pulse |
| flag_clr | input | 1 | Write-one-to-clear strobe for `done_flag` |
| sel_wr | input | 1 | Write strobe for the shadow select register |
| sel_wdata | input | SEL_W | Select word written by the CPU |
| sel_active | output | SEL_W | Active (possibly frozen) select word |
| sh_pulse | output | 1 | Sample-and-hold pulse |
| busy | output | 1 | Start bit read-back: pending or running conversion |
| done_flag | output | 1 | Sticky completion flag |
| res_latch | output | 1 | Result-capture strobe |

## Verification
A wrong half-step counter or a wrong kind selection shows at the ports as `sh_pulse` and `res_latch` on the wrong tick index. That error appears within one conversion, at most 50 half-steps. A phase bit out of step shifts every software or trigger start by one tick, and it is exposed by starting from both tick parities. A lock window that is too long or too short shows as `sel_active` changing either mid-conversion or only after completion. The bench probes this on the ticks just before and just after half-step LEN-2. An abort that leaves state behind shows as a stray `res_latch`, or as the 26-step timing after re-enable in place of the 50-step timing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_FIRST  = 2'd0,
    KIND_NORMAL = 2'd1,
    KIND_AUTO   = 2'd2
  } conv_kind_e;
endpackage

// File: rtl/adc_seq_sel_buf.sv
module adc_seq_sel_buf #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  input  logic             open_i,
  output logic [SEL_W-1:0] active_o
);
  logic [SEL_W-1:0] shadow_q;

  // shadow: CPU side, any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow_q <= '0;
    else if (wr) shadow_q <= wdata;
  end

  // active: follows shadow unless the timer holds the lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_o <= '0;
    else if (open_i) active_o <= shadow_q;
  end
endmodule

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       en,
  input  logic       auto_en,
  input  logic       free_run,
  input  logic       start_wr,
  input  logic       trig,
  input  logic       conv_on,
  input  logic       done_now,
  output logic       fire,
  output conv_kind_e fire_kind,
  output logic       pending
);
  logic ph_q;       // 0: next tick is a rising converter edge
  logic pend_sw_q;
  logic pend_at_q;
  logic first_q;
  logic edge_go;
  logic chain;

  assign edge_go = en && half_tick && !ph_q && !conv_on && (pend_sw_q || pend_at_q);
  assign chain   = done_now && en && auto_en && free_run;
  assign fire    = edge_go || chain;
  assign pending = pend_sw_q || pend_at_q;

  always_comb begin
    if (first_q)        fire_kind = KIND_FIRST;
    else if (chain)     fire_kind = KIND_AUTO;
    else if (pend_sw_q) fire_kind = KIND_NORMAL;
    else                fire_kind = KIND_AUTO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph_q <= 1'b0;
    else if (half_tick) ph_q <= !ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sw_q <= 1'b0;
      pend_at_q <= 1'b0;
      first_q   <= 1'b1;
    end else if (!en) begin
      pend_sw_q <= 1'b0;
      pend_at_q <= 1'b0;
      first_q   <= 1'b1;
    end else if (edge_go) begin
      pend_sw_q <= 1'b0;
      pend_at_q <= 1'b0;
      first_q   <= 1'b0;
    end else begin
      if (start_wr && !conv_on)        pend_sw_q <= 1'b1;
      if (trig && auto_en && !conv_on) pend_at_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int FIRST_LEN_H = 50,
  parameter int FIRST_SH_H  = 27,
  parameter int NORM_LEN_H  = 26,
  parameter int NORM_SH_H   = 3,
  parameter int AUTO_LEN_H  = 27,
  parameter int AUTO_SH_H   = 4,
  localparam int HC_W       = $clog2(FIRST_LEN_H + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       half_tick,
  input  logic       fire,
  input  conv_kind_e fire_kind,
  output logic       conv_on,
  output logic       done_now,
  output logic       open_o,
  output logic       sh_p,
  output logic       done_p
);
  localparam logic [HC_W-1:0] L_FIRST = HC_W'(FIRST_LEN_H);
  localparam logic [HC_W-1:0] L_NORM  = HC_W'(NORM_LEN_H);
  localparam logic [HC_W-1:0] L_AUTO  = HC_W'(AUTO_LEN_H);
  localparam logic [HC_W-1:0] S_FIRST = HC_W'(FIRST_SH_H);
  localparam logic [HC_W-1:0] S_NORM  = HC_W'(NORM_SH_H);
  localparam logic [HC_W-1:0] S_AUTO  = HC_W'(AUTO_SH_H);

  conv_kind_e      kind_q;
  logic [HC_W-1:0] hc_q;
  logic [HC_W-1:0] hc_nx;
  logic [HC_W-1:0] len_h;
  logic [HC_W-1:0] sh_h;
  logic            step;
  logic            sh_now;

  always_comb begin
    case (kind_q)
      KIND_FIRST:  begin len_h = L_FIRST; sh_h = S_FIRST; end
      KIND_NORMAL: begin len_h = L_NORM;  sh_h = S_NORM;  end
      default:     begin len_h = L_AUTO;  sh_h = S_AUTO;  end
    endcase
  end

  assign hc_nx    = hc_q + 1'b1;
  assign step     = conv_on && en && half_tick;
  assign done_now = step && (hc_nx == len_h);
  assign sh_now   = step && (hc_nx == sh_h);
  assign open_o   = !conv_on || (hc_q >= len_h - HC_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_on <= 1'b0;
      hc_q    <= '0;
      kind_q  <= KIND_FIRST;
    end else if (!en) begin
      conv_on <= 1'b0;
      hc_q    <= '0;
    end else if (fire) begin
      conv_on <= 1'b1;
      hc_q    <= '0;
      kind_q  <= fire_kind;
    end else if (done_now) begin
      conv_on <= 1'b0;
    end else if (step) begin
      hc_q    <= hc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_p   <= 1'b0;
      done_p <= 1'b0;
    end else begin
      sh_p   <= sh_now;
      done_p <= done_now;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_W       = 5,
  parameter int FIRST_LEN_H = 50,
  parameter int FIRST_SH_H  = 27,
  parameter int NORM_LEN_H  = 26,
  parameter int NORM_SH_H   = 3,
  parameter int AUTO_LEN_H  = 27,
  parameter int AUTO_SH_H   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             en,
  input  logic             auto_en,
  input  logic             free_run,
  input  logic             start_wr,
  input  logic             trig,
  input  logic             flag_clr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_active,
  output logic             sh_pulse,
  output logic             busy,
  output logic             done_flag,
  output logic             res_latch
);
  logic       conv_on;
  logic       done_now;
  logic       lock_open;
  logic       fire;
  logic       pending;
  conv_kind_e fire_kind;

  adc_seq_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .en        (en),
    .auto_en   (auto_en),
    .free_run  (free_run),
    .start_wr  (start_wr),
    .trig      (trig),
    .conv_on   (conv_on),
    .done_now  (done_now),
    .fire      (fire),
    .fire_kind (fire_kind),
    .pending   (pending)
  );

  adc_seq_timer #(
    .FIRST_LEN_H (FIRST_LEN_H),
    .FIRST_SH_H  (FIRST_SH_H),
    .NORM_LEN_H  (NORM_LEN_H),
    .NORM_SH_H   (NORM_SH_H),
    .AUTO_LEN_H  (AUTO_LEN_H),
    .AUTO_SH_H   (AUTO_SH_H)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .half_tick (half_tick),
    .fire      (fire),
    .fire_kind (fire_kind),
    .conv_on   (conv_on),
    .done_now  (done_now),
    .open_o    (lock_open),
    .sh_p      (sh_pulse),
    .done_p    (res_latch)
  );

  adc_seq_sel_buf #(.SEL_W(SEL_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (sel_wr),
    .wdata    (sel_wdata),
    .open_i   (lock_open),
    .active_o (sel_active)
  );

  // sticky completion flag, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (done_now) done_flag <= 1'b1;
    else if (flag_clr) done_flag <= 1'b0;
  end

  assign busy = conv_on || pending;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             start_wr,
  input logic             flag_clr,
  input logic             lock_open,
  input logic [SEL_W-1:0] sel_active,
  input logic             sh_pulse,
  input logic             res_latch,
  input logic             done_flag,
  input logic             busy
);
  a_r3_frozen_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lock_open) |-> $stable(sel_active));

  a_r10_flag_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    res_latch |-> done_flag);

  a_r10_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_latch |=> !res_latch);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  a_r13_sh_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh_pulse |=> !sh_pulse);

  a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sh_pulse && !res_latch));

  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && en && !busy) |=> busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .start_wr   (start_wr),
  .flag_clr   (flag_clr),
  .lock_open  (lock_open),
  .sel_active (sel_active),
  .sh_pulse   (sh_pulse),
  .res_latch  (res_latch),
  .done_flag  (done_flag),
  .busy       (busy)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int SEL_W = 5;
  localparam int F_LEN = 50, F_SH = 27;
  localparam int N_LEN = 26, N_SH = 3;
  localparam int A_LEN = 27, A_SH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic en = 1'b0, auto_en = 1'b0, free_run = 1'b0;
  logic start_wr = 1'b0, trig = 1'b0, flag_clr = 1'b0, sel_wr = 1'b0;
  logic [SEL_W-1:0] sel_wdata = '0;
  logic [SEL_W-1:0] sel_active;
  logic sh_pulse, busy, done_flag, res_latch;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .en(en), .auto_en(auto_en),
    .free_run(free_run), .start_wr(start_wr), .trig(trig), .flag_clr(flag_clr),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_active(sel_active),
    .sh_pulse(sh_pulse), .busy(busy), .done_flag(done_flag), .res_latch(res_latch)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic tick_en = 1'b0;
  int dv = 0;
  int tidx = 0;
  int sh_seen = 0, done_seen = 0;
  int sh_log [0:63];
  int done_log [0:63];

  // half-step tick: one pulse every third clock
  always @(negedge clk) begin
    if (!tick_en) begin dv <= 0; half_tick <= 1'b0; end
    else begin dv <= (dv == 2) ? 0 : dv + 1; half_tick <= (dv == 0); end
  end

  always @(posedge clk) if (half_tick) tidx <= tidx + 1;

  always @(negedge clk) begin
    if (sh_pulse)  begin sh_log[sh_seen % 64] <= tidx - 1; sh_seen <= sh_seen + 1; end
    if (res_latch) begin done_log[done_seen % 64] <= tidx - 1; done_seen <= done_seen + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_tick(output int last);
    do @(posedge clk); while (!half_tick);
    @(negedge clk);
    last = tidx - 1;
  endtask

  task automatic wait_ticks(input int n);
    int l;
    for (int i = 0; i < n; i++) wait_tick(l);
  endtask

  task automatic wait_until_tick(input int idx);
    int l;
    l = tidx - 1;
    while (l < idx) wait_tick(l);
  endtask

  task automatic wait_dones(input int target);
    int c;
    c = 0;
    while (done_seen < target && c < 4000) begin @(negedge clk); c++; end
    @(negedge clk);
  endtask

  task automatic write_sel(input logic [SEL_W-1:0] v);
    sel_wdata = v; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  // issues a strobe right after a tick; returns the first rising-edge index after it
  task automatic sw_start(output int s);
    int l;
    wait_tick(l);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    s = (l + 1) + ((l + 1) % 2);
  endtask

  task automatic trig_pulse(output int s);
    int l;
    wait_tick(l);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    s = (l + 1) + ((l + 1) % 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int s, d0, sh0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done_flag == 0 && sh_pulse == 0 && res_latch == 0, "R1 flags", busy, 0);
    chk(sel_active == 0, "R1 sel", sel_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick_en = 1'b1;

    // R2 idle tracking, swept over several values
    for (int v = 1; v < 32; v += 7) begin
      write_sel(SEL_W'(v));
      @(negedge clk);
      chk(sel_active == SEL_W'(v), "R2 idle copy", sel_active, v);
    end

    // R6 first conversion with R3/R4 lock window, R5 start latency
    write_sel(5'd5);
    en = 1'b1;
    d0 = done_seen;
    sw_start(s);
    @(negedge clk);
    chk(busy == 1, "R5 busy after start", busy, 1);
    wait_until_tick(s + 5);
    write_sel(5'd9);
    @(negedge clk);
    chk(sel_active == 5, "R3 frozen mid", sel_active, 5);
    wait_until_tick(s + F_LEN - 3);
    @(negedge clk);
    chk(sel_active == 5, "R3 frozen until last cycle", sel_active, 5);
    wait_until_tick(s + F_LEN - 2);
    @(negedge clk);
    chk(sel_active == 9 && done_seen == d0, "R4 released before done", sel_active, 9);
    wait_dones(d0 + 1);
    chk(sh_log[(sh_seen - 1) % 64] == s + F_SH, "R6 first sh", sh_log[(sh_seen - 1) % 64], s + F_SH);
    chk(done_log[d0 % 64] == s + F_LEN, "R6 first done", done_log[d0 % 64], s + F_LEN);
    chk(busy == 0, "R5 busy cleared", busy, 0);
    chk(done_flag == 1, "R10 flag set", done_flag, 1);
    repeat (5) @(negedge clk);
    chk(done_flag == 1, "R10 flag held", done_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    chk(done_flag == 0, "R10 flag cleared", done_flag, 0);

    // R7 normal conversions from varied tick alignments
    for (int k = 0; k < 4; k++) begin
      wait_ticks(k);
      d0 = done_seen;
      sh0 = sh_seen;
      sw_start(s);
      wait_dones(d0 + 1);
      chk(sh_seen == sh0 + 1, "R13 one sh", sh_seen - sh0, 1);
      chk(sh_log[sh0 % 64] == s + N_SH, "R7 normal sh", sh_log[sh0 % 64], s + N_SH);
      chk(done_log[d0 % 64] == s + N_LEN, "R7 normal done", done_log[d0 % 64], s + N_LEN);
      chk(busy == 0, "R5 busy after normal", busy, 0);
    end

    // R8 auto-triggered, two alignments
    auto_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      wait_ticks(k);
      d0 = done_seen;
      sh0 = sh_seen;
      trig_pulse(s);
      wait_dones(d0 + 1);
      chk(sh_log[sh0 % 64] == s + A_SH, "R8 auto sh", sh_log[sh0 % 64], s + A_SH);
      chk(done_log[d0 % 64] == s + A_LEN, "R8 auto done", done_log[d0 % 64], s + A_LEN);
    end

    // R9 free running chain
    free_run = 1'b1;
    d0 = done_seen;
    sh0 = sh_seen;
    trig_pulse(s);
    wait_dones(d0 + 3);
    free_run = 1'b0;
    chk(done_log[d0 % 64] == s + A_LEN, "R9 chain first", done_log[d0 % 64], s + A_LEN);
    for (int j = 1; j < 3; j++) begin
      chk(done_log[(d0 + j) % 64] - done_log[(d0 + j - 1) % 64] == A_LEN, "R9 chain period",
          done_log[(d0 + j) % 64] - done_log[(d0 + j - 1) % 64], A_LEN);
      chk(sh_log[(sh0 + j) % 64] == done_log[(d0 + j - 1) % 64] + A_SH, "R9 chained sh",
          sh_log[(sh0 + j) % 64], done_log[(d0 + j - 1) % 64] + A_SH);
    end
    wait_dones(d0 + 4);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9 chain stops", busy, 0);
    auto_en = 1'b0;

    // R11 abort and re-arm of first timing
    d0 = done_seen;
    sw_start(s);
    wait_ticks(10);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R11 abort busy", busy, 0);
    wait_ticks(40);
    chk(done_seen == d0, "R11 no completion after abort", done_seen - d0, 0);
    en = 1'b1;
    sh0 = sh_seen;
    sw_start(s);
    wait_dones(d0 + 1);
    chk(sh_log[sh0 % 64] == s + F_SH, "R11 first sh again", sh_log[sh0 % 64], s + F_SH);
    chk(done_log[d0 % 64] == s + F_LEN, "R11 first done again", done_log[d0 % 64], s + F_LEN);

    // R12 ignored starts and triggers
    en = 1'b0;
    auto_en = 1'b1;
    @(negedge clk);
    d0 = done_seen;
    sw_start(s);
    trig_pulse(s);
    @(negedge clk);
    chk(busy == 0, "R12 disabled busy", busy, 0);
    en = 1'b1;
    auto_en = 1'b0;
    trig_pulse(s);
    @(negedge clk);
    chk(busy == 0, "R12 trig without auto_en", busy, 0);
    wait_ticks(60);
    chk(done_seen == d0, "R12 no completion", done_seen - d0, 0);

    summary();
  end
endmodule